// File: doc/BRIEF.md
# Code-Word Watchdog Timer with Service Window

This block is a watchdog for a small processor subsystem. A free-running prescaler produces a tick at one of four selectable rates. Each tick advances an 8-bit up counter. When the counter passes its top value, the block raises a one-cycle request. The request goes either to a non-maskable interrupt line or to a reset-request line, as a control bit selects.

Software drives the block through a plain write strobe with an address and a data byte. One address holds a control byte with these fields:
- a run enable;
- a service-window select;
- a tick-rate select;
- the request routing.

The other address takes code words. Only exact code values act:
- One value restarts the count.
- Another value stops the watchdog, and only while the enable bit in the control byte is low.

All other values are ignored.

The service window can forbid servicing too early. A restart code that arrives before a set fraction of the count has elapsed is treated as a malfunction. It raises the same request as an overflow.

Top module: `cwdog_top`

## Requirements
- R1: Out of reset both request outputs are low. The watchdog is running with the slowest tick rate (code 11), no service window, and requests routed to the reset line. The first reset request therefore comes about 256 × 2^(TAP_BASE+3·TAP_STEP) cycles after reset, and no interrupt request is raised.
- R2: Writing 0x4E to the code address (address 1) sets the counter to zero. Counting then carries on, so the next overflow comes 256 ticks after the write.
- R3: When control bit 0 is 0, an overflow raises `nmi_req` and leaves `rst_req` low. The pulse is visible in the cycle after the clock edge on which the 256th tick lands.
- R4: When control bit 0 is 1, an overflow raises `rst_req` instead, and `nmi_req` stays low.
- R5: If a 0x4E write is taken on the same edge as an overflow, the counter is set to zero and no request is raised.
- R6: Writing 0xB1 to the code address stops the watchdog only while control bit 7 (enable) is 0. Clearing bit 7 alone does not stop it. A stopped watchdog raises no request. A later control write with bit 7 set restarts it with the count at zero.
- R7: A 0xB1 write while control bit 7 is 1 has no effect: the pending overflow still arrives at its original time.
- R8: Code values other than 0x4E and 0xB1 leave the counter unchanged.
- R9: Control bits 5:4 select the service window. Code 00 means no restriction. Codes 01, 10 and 11 open the window at counts 64, 128 and 192. A 0x4E write taken while the count is below the opening value raises a request and also zeroes the counter. A write at or above the opening value raises nothing.
- R10: Control bits 2:1 select the tick period 2^(TAP_BASE+TAP_STEP·code) cycles. The overflow therefore comes 256 periods after a restart, and up to one period minus one cycle earlier, because the prescaler phase is free-running.
- R11: Each request is a single-cycle pulse, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: CTRL_ADDR (0) is the control byte, CODE_ADDR (1) takes code words |
| wr_data | input | 8 | Write data |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The cases hardest to reach are the ones that depend on the exact counter value at the moment a code word arrives:
- a restart that lands on the very edge of an overflow;
- a restart one count below a window's opening value;
- a restart exactly at that opening value.

None of these can be seen at the ports. The bench therefore builds the block with a prescaler whose fastest setting ticks on every cycle. In that setting, the number of edges since the last restart write equals the counter value. The bench counts edges from a restart and places the next write on the edge it needs.

// File: rtl/cwdog_pkg.sv
// Package: shared types and code words for the code-word watchdog.
// Assumes an 8-bit software data path; field positions are fixed here.
package cwdog_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CODE_RESTART = 8'h4E;
    localparam logic [DATA_W-1:0] CODE_STOP    = 8'hB1;

    // Decoded control byte: bit 7 enable, bits 5:4 window, bits 2:1 tick select, bit 0 routing.
    typedef struct packed {
        logic       en;
        logic [1:0] win;
        logic [1:0] tsel;
        logic       to_rst;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{en: 1'b1, win: 2'b00, tsel: 2'b11, to_rst: 1'b1};

endpackage

// File: rtl/cwdog_prescale.sv
// Module: free-running prescaler with four selectable tick rates.
// Tap g ticks once every 2^(TAP_BASE+g*TAP_STEP) cycles; the phase is never reset
// by software, so the first period after a restart may be short.
module cwdog_prescale #(
    parameter int TAP_BASE = 10,
    parameter int TAP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tsel,
    output logic       tick
);
    localparam int PW_RAW = TAP_BASE + 3 * TAP_STEP;
    localparam int PW     = (PW_RAW < 1) ? 1 : PW_RAW;

    logic [PW-1:0] pre_q;
    logic [3:0]    hit;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // One tick candidate per selectable rate.
    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int EXP = TAP_BASE + g * TAP_STEP;
        localparam logic [PW-1:0] MASK = {PW{1'b1}} >> (PW - EXP);
        assign hit[g] = ((pre_q & MASK) == MASK);
    end

    assign tick = hit[tsel];

endmodule

// File: rtl/cwdog_regs.sv
// Module: control byte and code-word decode.
// Holds the control fields and the running state; a stop code is honoured only
// while the enable bit is low, and a control write with enable high restarts.
module cwdog_regs
    import cwdog_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0,
    parameter int CODE_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              run,
    output logic              restart
);
    logic ctrl_wr, code_wr, stop_wr;

    // Address and code decode.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
        code_wr = wr_en && (wr_addr == ADDR_W'(CODE_ADDR));
        restart = code_wr && (wr_data == CODE_RESTART);
        stop_wr = code_wr && (wr_data == CODE_STOP);
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl.en     <= wr_data[7];
            ctrl.win    <= wr_data[5:4];
            ctrl.tsel   <= wr_data[2:1];
            ctrl.to_rst <= wr_data[0];
        end
    end

    // Running state: set by enabling, cleared by a stop code while enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run <= 1'b1;
        else if (ctrl_wr && wr_data[7]) run <= 1'b1;
        else if (stop_wr && !ctrl.en)  run <= 1'b0;
    end

endmodule

// File: rtl/cwdog_core.sv
// Module: watchdog counter, service-window check and request pulses.
// Assumes one tick per prescaler period; a restart beats a coincident overflow,
// and an early restart still zeroes the count while flagging a malfunction.
module cwdog_core
    import cwdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  run,
    input  logic  tick,
    input  logic  restart,
    output logic  nmi_req,
    output logic  rst_req
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] open_at;
    logic             ovf, early, fire;

    // Window opening count and trigger conditions.
    always_comb begin
        open_at = {ctrl.win, {(CNT_W-2){1'b0}}};
        ovf     = run && tick && (cnt_q == CNT_TOP) && !restart;
        early   = run && restart && (cnt_q < open_at);
        fire    = ovf || early;
    end

    // Up counter: held at zero while stopped, zeroed by restart, advanced by tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    // Registered one-cycle request pulses, routed by the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_req <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            nmi_req <= fire && !ctrl.to_rst;
            rst_req <= fire &&  ctrl.to_rst;
        end
    end

endmodule

// File: rtl/cwdog_top.sv
// Module: code-word watchdog top; joins prescaler, register decode and core.
// Assumes a single clock domain and a write strobe valid for one cycle per write.
module cwdog_top
    import cwdog_pkg::*;
#(
    parameter int TAP_BASE  = 10,
    parameter int TAP_STEP  = 2,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0,
    parameter int CODE_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              nmi_req,
    output logic              rst_req
);
    ctrl_t ctrl;
    logic  run, restart, tick;

    cwdog_regs #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CODE_ADDR(CODE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .run(run), .restart(restart)
    );

    cwdog_prescale #(
        .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .tsel(ctrl.tsel), .tick(tick)
    );

    cwdog_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .run(run), .tick(tick),
        .restart(restart), .nmi_req(nmi_req), .rst_req(rst_req)
    );

endmodule

// File: rtl/cwdog_chk.sv
// Module: property checker for the code-word watchdog, bound into cwdog_top.
// Assumes it sees the decoded control fields, the running state and the restart strobe.
module cwdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nmi_req,
    input logic       rst_req,
    input logic       run,
    input logic       en,
    input logic [1:0] win,
    input logic       to_rst,
    input logic       restart
);
    p_one_cycle_nmi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    p_one_cycle_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_never_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && rst_req));

    p_nmi_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> !$past(to_rst));

    p_rst_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(to_rst));

    p_restart_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && run && win == 2'b00) |=> !(nmi_req || rst_req));

    p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(nmi_req || rst_req));

    p_stop_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en) |=> run);

endmodule

bind cwdog_top cwdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .rst_req(rst_req),
    .run(run), .en(ctrl.en), .win(ctrl.win), .to_rst(ctrl.to_rst),
    .restart(restart)
);

// File: tb/cwdog_top_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the code-word watchdog, one task each.
// Built with TAP_BASE=0, TAP_STEP=1 so tick code 00 ticks on every cycle.
module cwdog_top_tb;
    localparam int CTRL = 0;
    localparam int CODE = 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [0:0] wr_addr;
    logic [7:0] wr_data;
    logic       nmi_req, rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    int nmi_seen = 0;
    int rst_seen = 0;

    cwdog_top #(.TAP_BASE(0), .TAP_STEP(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    // Pulse counters sampled just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (nmi_req) nmi_seen++;
        if (rst_req) rst_seen++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cbyte(input bit en, input logic [1:0] win,
                                         input logic [1:0] tsel, input bit to_rst);
        return {en, 1'b0, win, 1'b0, tsel, to_rst};
    endfunction

    // Called at a falling edge; the write is taken on the next rising edge.
    task automatic wr(input int addr, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_addr = addr[0:0];
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] tsel, input bit to_rst);
        wr(CTRL, cbyte(1'b1, 2'b00, tsel, to_rst));
        wr(CODE, 8'h4E);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        wait_n(4);
        check(nmi_req == 1'b0, "R1 nmi_req in reset", nmi_req, 0);
        check(rst_req == 1'b0, "R1 rst_req in reset", rst_req, 0);
        rst_n = 1'b1;
        wait_n(2000);
        check(rst_seen == 0, "R1 no early reset request", rst_seen, 0);
        wait_n(100);
        check(rst_seen == 1, "R1 reset request after slowest period", rst_seen, 1);
        check(nmi_seen == 0, "R1 no interrupt request by default", nmi_seen, 0);
    endtask

    task automatic t_restart();
        int b;
        setup(2'b00, 1'b0);
        wait_n(200);
        b = nmi_seen;
        wr(CODE, 8'h4E);
        wait_n(255);
        check(nmi_seen == b, "R2 no overflow before 256 ticks from restart", nmi_seen - b, 0);
        wait_n(1);
        check(nmi_req == 1'b1, "R3 nmi_req at overflow", nmi_req, 1);
        check(rst_req == 1'b0, "R3 rst_req low with interrupt routing", rst_req, 0);
        wait_n(1);
        check(nmi_req == 1'b0, "R11 interrupt pulse lasts one cycle", nmi_req, 0);
    endtask

    task automatic t_reset_route();
        int b;
        setup(2'b00, 1'b1);
        b = nmi_seen;
        wait_n(256);
        check(rst_req == 1'b1, "R4 rst_req at overflow", rst_req, 1);
        check(nmi_seen == b, "R4 no interrupt with reset routing", nmi_seen - b, 0);
        wait_n(1);
        check(rst_req == 1'b0, "R11 reset pulse lasts one cycle", rst_req, 0);
    endtask

    task automatic t_restart_wins();
        int b;
        setup(2'b00, 1'b0);
        wait_n(255);
        b = nmi_seen;
        wr(CODE, 8'h4E);
        check(nmi_req == 1'b0 && nmi_seen == b, "R5 restart on overflow edge suppresses request",
              nmi_seen - b, 0);
        wait_n(255);
        check(nmi_seen == b, "R5 count was zeroed by the coincident restart", nmi_seen - b, 0);
        wait_n(1);
        check(nmi_req == 1'b1, "R5 next overflow 256 ticks later", nmi_req, 1);
    endtask

    task automatic t_stop();
        int b;
        wr(CTRL, cbyte(1'b0, 2'b00, 2'b00, 1'b0));
        wr(CODE, 8'h4E);
        wait_n(256);
        check(nmi_req == 1'b1, "R6 enable low alone keeps watchdog running", nmi_req, 1);
        wr(CODE, 8'hB1);
        b = nmi_seen;
        wait_n(600);
        check(nmi_seen == b, "R6 stopped watchdog raises nothing", nmi_seen - b, 0);
        wr(CTRL, cbyte(1'b1, 2'b00, 2'b00, 1'b0));
        wait_n(255);
        check(nmi_seen == b, "R6 restart after enable begins at zero", nmi_seen - b, 0);
        wait_n(1);
        check(nmi_req == 1'b1, "R6 overflow 256 ticks after re-enable", nmi_req, 1);
    endtask

    task automatic t_stop_blocked();
        int b;
        setup(2'b00, 1'b0);
        b = nmi_seen;
        wr(CODE, 8'hB1);
        wait_n(254);
        check(nmi_seen == b, "R7 no request before original overflow", nmi_seen - b, 0);
        wait_n(1);
        check(nmi_req == 1'b1, "R7 stop code ignored while enabled", nmi_req, 1);
    endtask

    task automatic t_other_codes();
        int b;
        setup(2'b00, 1'b0);
        b = nmi_seen;
        wait_n(100);
        wr(CODE, 8'h4D);
        wr(CODE, 8'h00);
        wr(CODE, 8'hFF);
        wait_n(152);
        check(nmi_seen == b, "R8 no early request after other codes", nmi_seen - b, 0);
        wait_n(1);
        check(nmi_req == 1'b1, "R8 other codes left count unchanged", nmi_req, 1);
    endtask

    task automatic t_window(input logic [1:0] win, input int thr);
        int b;
        setup(2'b00, 1'b0);
        wr(CTRL, cbyte(1'b1, win, 2'b00, 1'b0));
        wr(CODE, 8'h4E);
        check(nmi_req == 1'b1, $sformatf("R9 win %0d restart at count 1 is early", win), nmi_req, 1);
        wait_n(thr - 1);
        wr(CODE, 8'h4E);
        check(nmi_req == 1'b1, $sformatf("R9 win %0d restart one below opening", win), nmi_req, 1);
        b = nmi_seen;
        wait_n(thr);
        wr(CODE, 8'h4E);
        check(nmi_req == 1'b0 && nmi_seen == b,
              $sformatf("R9 win %0d restart at opening is legal", win), nmi_seen - b, 0);
        wr(CTRL, cbyte(1'b1, 2'b00, 2'b00, 1'b0));
    endtask

    task automatic t_tap(input logic [1:0] tsel, input int per);
        int b;
        setup(tsel, 1'b0);
        b = nmi_seen;
        wait_n(256 * per - per);
        check(nmi_seen == b, $sformatf("R10 tick code %0d no early overflow", tsel), nmi_seen - b, 0);
        wait_n(per);
        check(nmi_seen == b + 1, $sformatf("R10 tick code %0d overflow in window", tsel),
              nmi_seen - b, 1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: bench did not finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_restart();
        t_reset_route();
        t_restart_wins();
        t_stop();
        t_stop_blocked();
        t_other_codes();
        t_window(2'b01, 64);
        t_window(2'b10, 128);
        t_window(2'b11, 192);
        t_tap(2'b01, 2);
        t_tap(2'b10, 4);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule